// File: doc/BRIEF.md
# Doorbell Handshake Command Sender

This block sits on the host side of a link to a peer controller. The only path between the two is a shared doorbell register. A pulse on `start` carries a message length in bytes. The block then reads the doorbell to confirm that the peer can accept a message. If an interrupt from an earlier exchange is still pending, it clears it. It writes a length-announce word and then pushes the message one 32-bit word at a time. Before it writes each new word, it polls until the peer acknowledges the last one. Message words come from a local buffer, which the block addresses by word index and reads back combinationally.

The block starts every register access with a one-cycle strobe. Read data returns on `reg_rdata` in the cycle after a read strobe. Each wait on the peer is a bounded poll loop: read the interrupt status register, test one bit, then pause for a parameterised number of cycles. When the poll budget runs out, the transfer is abandoned. At the end, `done` pulses for one cycle with a result code: OK, BUSY (the precondition was refused) or TIMEOUT.

Top module: `dbhs_sender`

## Requirements
- R1: After `start`, the block reads the doorbell (`reg_sel`=0). Doorbell bits 31:28 hold the peer state and bit 27 is the in-use flag. If the state is not 1, 2 or 4, or the in-use flag is set, the transfer ends with result BUSY (1) and no register write is made.
- R2: The announce word is written to the doorbell. It carries function code 0x42 in bits 31:24, the dword count ceil(len/4) in bits 23:16, and zero in bits 15:0.
- R3: If bit 0 (doorbell interrupt) of the interrupt status register (`reg_sel`=1) reads 1 before the announce, the block writes zero to the interrupt status register ahead of the announce; otherwise it makes no such write. Every write to the interrupt status register carries zero.
- R4: After the announce, the block polls the interrupt status register until bit 0 is 1. It then writes zero to that register and polls until bit 31 (busy) is 0 before it writes the first message word. At most one register access is made per cycle.
- R5: Message words at buffer indexes 0 to n-1 are written to the doorbell in order, and each write waits for bit 31 to clear after the one before. A zero-length message writes no data words and ends OK (0).
- R6: Each wait makes at most MAX_POLLS reads of the interrupt status register. If the last of them fails, the transfer ends with TIMEOUT (2) and no further write follows.
- R7: Consecutive polls of a wait are spaced POLL_DELAY+2 cycles apart.
- R8: `done` is high for exactly one cycle, with `result` valid in that same cycle. `busy` is high from the cycle after an accepted `start` up to and including the `done` cycle, and is low in the cycle after.
- R9: A `start` pulse while `busy` is high is ignored: the writes and the result of the running transfer do not change, and no second `done` follows.
- R10: After reset, `busy`, `done`, `reg_rd` and `reg_wr` are low, and no strobe is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| len_bytes | input | LEN_W | Message length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 BUSY, 2 TIMEOUT |
| buf_addr | output | LEN_W-1 | Index of the message word being sent |
| buf_data | input | 32 | Message word at `buf_addr` |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 1 | 0 doorbell, 1 interrupt status |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_rd` |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse carrying a legal code and is followed by idle, and that no strobe fires while idle. They also check that a read and a write never coincide, that every interrupt-status write carries zero, that a refused precondition leaves no write behind, and that no wait reads the status register more than MAX_POLLS times. The order and content of the announce and data words, the rounding of the dword count, the clearing of a stale interrupt, the poll spacing and the ignoring of a second start depend on how the peer answers. Only the bench's scenarios can show these, using a modelled peer that can withhold its interrupt or its acknowledge.

// File: rtl/dbhs_pkg.sv
package dbhs_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_BUSY    = 2'd1,
    RES_TIMEOUT = 2'd2
  } res_e;

  localparam logic SEL_DB = 1'b0;
  localparam logic SEL_IS = 1'b1;

  localparam logic [7:0] FN_HANDSHAKE = 8'h42;

  localparam logic [3:0] PST_READY   = 4'd1;
  localparam logic [3:0] PST_RUNNING = 4'd2;
  localparam logic [3:0] PST_FAULT   = 4'd4;

  localparam int IS_INT_BIT  = 0;
  localparam int IS_BUSY_BIT = 31;
  localparam int DB_USE_BIT  = 27;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_DB, S_CHK_DB, S_RD_IS, S_CHK_IS, S_CLR_PRE,
    S_ANNOUNCE, S_POLL_RD, S_POLL_CHK, S_POLL_DLY, S_CLR_INT,
    S_WR_DATA, S_DONE
  } seq_state_e;

  typedef enum logic {
    PH_INT = 1'b0,
    PH_ACK = 1'b1
  } wait_phase_e;

endpackage

// File: rtl/dbhs_rst_sync.sv
module dbhs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dbhs_dword_count.sv
module dbhs_dword_count #(
  parameter int LEN_W = 9
) (
  input  logic [LEN_W-1:0] len_bytes,
  output logic [LEN_W-2:0] dword_cnt
);
  logic [LEN_W:0] rounded;

  always_comb begin
    rounded   = {1'b0, len_bytes} + (LEN_W+1)'(3);
    dword_cnt = rounded[LEN_W:2];
  end
endmodule

// File: rtl/dbhs_poll_timer.sv
module dbhs_poll_timer #(
  parameter int MAX_POLLS  = 300000,
  parameter int POLL_DELAY = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_begin,
  input  logic poll_chk,
  input  logic dly_run,
  output logic last_poll,
  output logic dly_done
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int DW = $clog2(POLL_DELAY + 1);

  logic [PW-1:0] poll_q, poll_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          poll_en, dly_en;

  always_comb begin
    poll_en = wait_begin | poll_chk;
    poll_d  = wait_begin ? '0 : poll_q + PW'(1);
    dly_en  = 1'b1;
    dly_d   = dly_run ? dly_q + DW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= '0;
      dly_q  <= '0;
    end else begin
      if (poll_en) poll_q <= poll_d;
      if (dly_en)  dly_q  <= dly_d;
    end
  end

  assign last_poll = (poll_q == PW'(MAX_POLLS - 1));
  assign dly_done  = dly_run && (dly_q == DW'(POLL_DELAY - 1));
endmodule

// File: rtl/dbhs_seq.sv
module dbhs_seq
  import dbhs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dword_cnt,
  input  logic [31:0]      reg_rdata,
  input  logic [31:0]      buf_data,
  input  logic             last_poll,
  input  logic             dly_done,
  output logic             wait_begin,
  output logic             poll_chk,
  output logic             dly_run,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic             reg_sel,
  output logic [31:0]      reg_wdata,
  output logic [CNT_W-1:0] buf_addr,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);
  seq_state_e       state_q, state_d;
  wait_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] idx_q, idx_d, cnt_q, cnt_d;
  res_e             res_q, res_d;
  logic [3:0]       peer_state;
  logic             peer_ok, cond_met;
  logic [7:0]       cnt_field;
  logic             unused_rdata;

  assign unused_rdata = ^reg_rdata[26:1];

  always_comb begin
    peer_state = reg_rdata[31:28];
    peer_ok    = ((peer_state == PST_READY) || (peer_state == PST_RUNNING) ||
                  (peer_state == PST_FAULT)) && !reg_rdata[DB_USE_BIT];
    cond_met   = (phase_q == PH_INT) ? reg_rdata[IS_INT_BIT] : !reg_rdata[IS_BUSY_BIT];
    cnt_field  = '0;
    cnt_field[CNT_W-1:0] = cnt_q;
  end

  always_comb begin
    state_d    = state_q;
    phase_d    = phase_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    res_d      = res_q;
    reg_rd     = 1'b0;
    reg_wr     = 1'b0;
    reg_sel    = SEL_DB;
    reg_wdata  = '0;
    wait_begin = 1'b0;
    poll_chk   = 1'b0;
    dly_run    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          cnt_d   = dword_cnt;
          idx_d   = '0;
          state_d = S_RD_DB;
        end
      end
      S_RD_DB: begin
        reg_rd  = 1'b1;
        reg_sel = SEL_DB;
        state_d = S_CHK_DB;
      end
      S_CHK_DB: begin
        if (peer_ok) begin
          state_d = S_RD_IS;
        end else begin
          res_d   = RES_BUSY;
          state_d = S_DONE;
        end
      end
      S_RD_IS: begin
        reg_rd  = 1'b1;
        reg_sel = SEL_IS;
        state_d = S_CHK_IS;
      end
      S_CHK_IS: begin
        state_d = reg_rdata[IS_INT_BIT] ? S_CLR_PRE : S_ANNOUNCE;
      end
      S_CLR_PRE: begin
        reg_wr  = 1'b1;
        reg_sel = SEL_IS;
        state_d = S_ANNOUNCE;
      end
      S_ANNOUNCE: begin
        reg_wr     = 1'b1;
        reg_sel    = SEL_DB;
        reg_wdata  = {FN_HANDSHAKE, cnt_field, 16'h0000};
        phase_d    = PH_INT;
        wait_begin = 1'b1;
        state_d    = S_POLL_RD;
      end
      S_POLL_RD: begin
        reg_rd  = 1'b1;
        reg_sel = SEL_IS;
        state_d = S_POLL_CHK;
      end
      S_POLL_CHK: begin
        poll_chk = 1'b1;
        if (cond_met) begin
          if (phase_q == PH_INT) begin
            state_d = S_CLR_INT;
          end else if (idx_q == cnt_q) begin
            res_d   = RES_OK;
            state_d = S_DONE;
          end else begin
            state_d = S_WR_DATA;
          end
        end else if (last_poll) begin
          res_d   = RES_TIMEOUT;
          state_d = S_DONE;
        end else begin
          state_d = S_POLL_DLY;
        end
      end
      S_POLL_DLY: begin
        dly_run = 1'b1;
        if (dly_done) state_d = S_POLL_RD;
      end
      S_CLR_INT: begin
        reg_wr     = 1'b1;
        reg_sel    = SEL_IS;
        phase_d    = PH_ACK;
        wait_begin = 1'b1;
        state_d    = S_POLL_RD;
      end
      S_WR_DATA: begin
        reg_wr     = 1'b1;
        reg_sel    = SEL_DB;
        reg_wdata  = buf_data;
        idx_d      = idx_q + CNT_W'(1);
        phase_d    = PH_ACK;
        wait_begin = 1'b1;
        state_d    = S_POLL_RD;
      end
      S_DONE: begin
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      phase_q <= PH_INT;
      idx_q   <= '0;
      cnt_q   <= '0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      res_q   <= res_d;
    end
  end

  assign buf_addr = idx_q;
  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_DONE);
  assign result   = res_q;
endmodule

// File: rtl/dbhs_sender.sv
module dbhs_sender #(
  parameter int LEN_W      = 9,
  parameter int MAX_POLLS  = 300000,
  parameter int POLL_DELAY = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_bytes,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic [LEN_W-2:0] buf_addr,
  input  logic [31:0]      buf_data,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic             reg_sel,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata
);
  localparam int CNT_W = LEN_W - 1;

  logic             rst_n_sync;
  logic [CNT_W-1:0] dword_cnt;
  logic             wait_begin, poll_chk, dly_run, last_poll, dly_done;

  dbhs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dbhs_dword_count #(.LEN_W(LEN_W)) u_cnt (
    .len_bytes (len_bytes),
    .dword_cnt (dword_cnt)
  );

  dbhs_poll_timer #(.MAX_POLLS(MAX_POLLS), .POLL_DELAY(POLL_DELAY)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wait_begin (wait_begin),
    .poll_chk   (poll_chk),
    .dly_run    (dly_run),
    .last_poll  (last_poll),
    .dly_done   (dly_done)
  );

  dbhs_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start      (start),
    .dword_cnt  (dword_cnt),
    .reg_rdata  (reg_rdata),
    .buf_data   (buf_data),
    .last_poll  (last_poll),
    .dly_done   (dly_done),
    .wait_begin (wait_begin),
    .poll_chk   (poll_chk),
    .dly_run    (dly_run),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .buf_addr   (buf_addr),
    .busy       (busy),
    .done       (done),
    .result     (result)
  );
endmodule

// File: rtl/dbhs_sender_chk.sv
module dbhs_sender_chk
  import dbhs_pkg::*;
#(
  parameter int MAX_POLLS = 300000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [1:0]  result,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [31:0] reg_wdata
);
  localparam int RW = $clog2(MAX_POLLS + 1) + 1;

  logic [RW-1:0] is_reads_q;
  logic          wrote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_reads_q <= '0;
      wrote_q    <= 1'b0;
    end else begin
      if (!busy || reg_wr)             is_reads_q <= '0;
      else if (reg_rd && reg_sel == SEL_IS) is_reads_q <= is_reads_q + RW'(1);
      if (!busy)       wrote_q <= 1'b0;
      else if (reg_wr) wrote_q <= 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));                                   // R8
  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3));                                   // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_rd && !reg_wr));                              // R10
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));                                         // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_IS) |-> (reg_wdata == 32'h0));      // R3
  AST_REFUSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_BUSY) |-> !wrote_q);                   // R1
  AST_POLL_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == SEL_IS) |-> (is_reads_q < RW'(MAX_POLLS))); // R6
endmodule

bind dbhs_sender dbhs_sender_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata)
);

// File: tb/dbhs_sender_tb.sv
module dbhs_sender_tb;
  localparam int LEN_W   = 9;
  localparam int NPOLL   = 6;
  localparam int DLY     = 3;
  localparam int INT_LAT = 4;
  localparam int ACK_LAT = 7;

  logic             clk, rst_n, start;
  logic [LEN_W-1:0] len_bytes;
  logic             busy, done, reg_rd, reg_wr, reg_sel;
  logic [1:0]       result;
  logic [LEN_W-2:0] buf_addr;
  logic [31:0]      buf_data, reg_wdata, reg_rdata;

  dbhs_sender #(.LEN_W(LEN_W), .MAX_POLLS(NPOLL), .POLL_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_bytes(len_bytes),
    .busy(busy), .done(done), .result(result), .buf_addr(buf_addr),
    .buf_data(buf_data), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] mem [0:127];
  assign buf_data = mem[buf_addr];

  // peer model controls
  logic [31:0] db_word;
  logic        peer_clr, pend_req, no_int;
  int          stuck_idx;
  logic        is_int, is_busy;
  int          int_tmr, ack_tmr, db_wr_idx;

  always @(posedge clk) begin
    if (!rst_n || peer_clr) begin
      is_int <= 1'b0; is_busy <= 1'b0; int_tmr <= 0; ack_tmr <= 0;
      db_wr_idx <= 0; reg_rdata <= '0;
    end else begin
      if (pend_req) is_int <= 1'b1;
      if (reg_rd) reg_rdata <= reg_sel ? {is_busy, 30'b0, is_int} : db_word;
      if (int_tmr > 0) begin
        int_tmr <= int_tmr - 1;
        if (int_tmr == 1) is_int <= 1'b1;
      end
      if (ack_tmr > 0) begin
        ack_tmr <= ack_tmr - 1;
        if (ack_tmr == 1) is_busy <= 1'b0;
      end
      if (reg_wr && reg_sel) is_int <= 1'b0;
      if (reg_wr && !reg_sel) begin
        is_busy <= 1'b1;
        if (db_wr_idx != stuck_idx) ack_tmr <= ACK_LAT;
        if (db_wr_idx == 0 && !no_int) int_tmr <= INT_LAT;
        db_wr_idx <= db_wr_idx + 1;
      end
    end
  end

  // scoreboard
  logic [32:0] exp_q[$];
  logic [1:0]  exp_res;
  string       tag;
  int          done_cnt, run_is, last_is_cyc, timeout_reads;
  logic        have_prev;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy) begin have_prev = 1'b0; run_is = 0; end
      if (reg_wr) begin
        have_prev = 1'b0;
        run_is = 0;
        if (exp_q.size() == 0) chk(1'b0, tag, "unexpected write", {31'b0, reg_sel, reg_wdata}, 64'h0);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk({reg_sel, reg_wdata} == e, tag, "write", {31'b0, reg_sel, reg_wdata}, {31'b0, e});
        end
      end
      if (reg_rd && reg_sel) begin
        if (have_prev) chk(cyc - last_is_cyc == DLY + 2, "R7", "poll spacing",
                           64'(cyc - last_is_cyc), 64'(DLY + 2));
        have_prev = 1'b1;
        last_is_cyc = cyc;
        run_is++;
      end
      if (done) begin
        done_cnt++;
        timeout_reads = run_is;
        chk(result == exp_res, tag, "result", 64'(result), 64'(exp_res));
      end
    end
  end

  task automatic run_case(input string t, input int len, input logic [3:0] pst,
                          input logic inuse, input logic pre, input logic noi,
                          input int stuck, input logic restart);
    int n;
    logic ok_pre;
    n = (len + 3) / 4;
    tag = t;
    for (int i = 0; i < 128; i++) mem[i] = 32'hC0DE0000 ^ (i * 32'h01030507) ^ (len << 8);
    ok_pre = (pst == 4'd1 || pst == 4'd2 || pst == 4'd4) && !inuse;
    exp_q.delete();
    if (!ok_pre) exp_res = 2'd1;
    else begin
      exp_res = 2'd0;
      if (pre) exp_q.push_back({1'b1, 32'h0});
      exp_q.push_back({1'b0, 8'h42, 8'(n), 16'h0});
      if (noi) exp_res = 2'd2;
      else begin
        exp_q.push_back({1'b1, 32'h0});
        if (stuck == 0) exp_res = 2'd2;
        else begin
          for (int i = 0; i < n; i++) begin
            exp_q.push_back({1'b0, mem[i]});
            if (stuck == i + 1) begin exp_res = 2'd2; break; end
          end
        end
      end
    end
    db_word = {pst, inuse, 27'h0};
    no_int = noi;
    stuck_idx = stuck;
    peer_clr = 1'b1;
    @(negedge clk);
    peer_clr = 1'b0;
    pend_req = pre;
    @(negedge clk);
    pend_req = 1'b0;
    done_cnt = 0;
    len_bytes = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    len_bytes = '0;
    chk(busy == 1'b1, "R8", "busy after start", 64'(busy), 64'h1);
    if (restart) begin
      repeat (4) @(negedge clk);
      len_bytes = LEN_W'(40);
      start = 1'b1;   // R9: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    begin
      int wd;
      wd = 0;
      while (done_cnt == 0 && wd < 4000) begin @(negedge clk); wd++; end
      if (wd >= 4000) chk(1'b0, tag, "watchdog expired", 64'(wd), 64'h0);
    end
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, restart ? "R9" : "R8", "done count", 64'(done_cnt), 64'h1);
    chk(exp_q.size() == 0, tag, "writes left unsent", 64'(exp_q.size()), 64'h0);
    chk(busy == 1'b0, "R8", "idle after done", 64'(busy), 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; len_bytes = '0; db_word = '0;
    peer_clr = 1'b0; pend_req = 1'b0; no_int = 1'b0; stuck_idx = -1;
    tag = "R10"; exp_res = 2'd0; done_cnt = 0; run_is = 0; last_is_cyc = 0;
    have_prev = 1'b0; timeout_reads = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !reg_rd && !reg_wr, "R10", "reset outputs",
        {60'h0, busy, done, reg_rd, reg_wr}, 64'h0);

    run_case("R2", 10, 4'd2, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_case("R3", 4, 4'd1, 1'b0, 1'b1, 1'b0, -1, 1'b0);
    run_case("R5", 0, 4'd4, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_case("R1", 8, 4'd0, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_case("R1", 8, 4'd2, 1'b1, 1'b0, 1'b0, -1, 1'b0);
    run_case("R1", 8, 4'd3, 1'b0, 1'b0, 1'b0, -1, 1'b0);
    run_case("R6", 12, 4'd2, 1'b0, 1'b0, 1'b1, -1, 1'b0);
    chk(timeout_reads == NPOLL, "R6", "poll reads before timeout", 64'(timeout_reads), 64'(NPOLL));
    run_case("R4", 12, 4'd2, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_case("R6", 13, 4'd2, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    chk(timeout_reads == NPOLL, "R6", "poll reads on stuck word", 64'(timeout_reads), 64'(NPOLL));
    run_case("R9", 20, 4'd2, 1'b0, 1'b0, 1'b0, -1, 1'b1);
    run_case("R2", 255, 4'd1, 1'b0, 1'b0, 1'b0, -1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule